// File: doc/BRIEF.md
# Byte-Wide EEPROM Access Sequencer

This block lets a host move single bytes to and from an external byte-wide EEPROM, and run a bulk load that copies tagged bytes from the EEPROM into on-chip memory. The host sees five word registers behind a simple write-strobe and read-mux port. A request bit starts an operation, and the hardware clears that bit when the operation finishes. The EEPROM is reached through a request/acknowledge byte port, so the serial protocol sits in a separate controller.

The bulk load reads records of three bytes each: a high address byte, a low address byte and one data byte. It writes the data byte to a 24-bit memory address. The top nine bits of that address come from a host base register. The low fifteen bits come from the record, and the top bit of the record address is dropped. A record address of 0xFFFF ends the load. A byte cursor remembers where the EEPROM was last touched. The first load after reset starts at EEPROM address 0. Every later load starts just after the last byte accessed, whether that byte came from a single access or from an earlier load.

Top module: `nvm_loader`

## Requirements
- R1: After reset every host register reads 0, `ee_req` and `mem_we` are low and busy is clear. Register word offsets on `h_addr`: 0 control, 1 EEPROM address (16 bits), 2 data, 3 burst start, 4 base (9 bits).
- R2: Writing 1 to control bit 0 writes the low 8 bits of the data register to the EEPROM at the address register. Bit 0 reads 0 again once the write is done.
- R3: Writing 1 to control bit 1 reads the EEPROM byte at the address register into the data register. Bit 1 clears when the read is done, and the new byte is readable from then on.
- R4: Control bit 2 is a read-only busy flag. It is 1 while any of control bit 0, control bit 1 or burst bit 0 is set. Host writes to any register are ignored while busy is 1.
- R5: If control bits 0 and 1 are written as 1 together, only the write is performed. The data register keeps its value.
- R6: `ee_req` stays high, and `ee_addr`, `ee_we` and `ee_wdata` stay stable, from the rise of `ee_req` until `ee_ack` is sampled high. `ee_req` falls on the next cycle.
- R7: Writing 1 to burst bit 0 starts a load, and the bit clears itself when the load ends. A load that comes after reset with no earlier single access starts at EEPROM address 0.
- R8: A load started after a single access to address A begins at A+1. A load started after an earlier load begins just after the last terminator byte of that load.
- R9: Each record is read as high byte, low byte, data byte. It produces exactly one `mem_we` pulse, at `mem_addr` = {base[8:0], record[14:0]}, with record bit 15 dropped.
- R10: A record address of 0xFFFF ends the load after its two address bytes. No data byte is read for it and nothing is written to memory.
- R11: The data register stores 8 bits. Bits 31:8 read as 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_we | input | 1 | Host register write strobe |
| h_addr | input | 3 | Host register word offset, used for both read and write |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for the register at `h_addr` (combinational) |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | 1 = write request, 0 = read request |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle acknowledge that completes a request |
| ee_rdata | input | 8 | Read byte, valid with `ee_ack` |
| mem_we | output | 1 | One-cycle on-chip memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The assertions check four things on every cycle:
- the EEPROM handshake holds its request stable and releases it right after an acknowledge;
- at most one request bit is ever set;
- register writes during busy leave the address and base registers unchanged;
- every memory write is a single-cycle pulse that carries the base register in its top bits.

Only the bench scenarios can show the rest:
- where the byte cursor resumes between loads and single accesses;
- the record parsing, including the dropped address bit;
- the silent end on the terminator;
- the write-over-read priority.

// File: rtl/nvm_pkg.sv
// Shared register offsets, control bit positions and sequencer states.
// Assumes a word-indexed host register port of three address bits.
package nvm_pkg;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_ADDR  = 3'd1;
    localparam logic [2:0] OFS_DATA  = 3'd2;
    localparam logic [2:0] OFS_BURST = 3'd3;
    localparam logic [2:0] OFS_BASE  = 3'd4;

    localparam int CTL_WR   = 0;
    localparam int CTL_RD   = 1;
    localparam int CTL_BUSY = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_HI,
        ST_LO,
        ST_DAT
    } seq_state_t;

endpackage

// File: rtl/nvm_ee_if.sv
// EEPROM request/acknowledge driver. A one-cycle go pulse, taken while no
// request is open, latches the address, direction and write byte and raises
// ee_req. The first sampled ee_ack closes the request. done pulses one cycle
// later, together with the captured read byte.
// Assumes the EEPROM side gives exactly one ack per request.
module nvm_ee_if #(
    parameter int EE_AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_we,
    input  logic [EE_AW-1:0] go_addr,
    input  logic [7:0]       go_wdata,
    output logic             ee_req,
    output logic             ee_we,
    output logic [EE_AW-1:0] ee_addr,
    output logic [7:0]       ee_wdata,
    input  logic             ee_ack,
    input  logic [7:0]       ee_rdata,
    output logic             done,
    output logic [7:0]       rd_byte
);

    // Open a request on go, close it on ack, and capture the returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee_req   <= 1'b0;
            ee_we    <= 1'b0;
            ee_addr  <= '0;
            ee_wdata <= '0;
            rd_byte  <= '0;
        end else if (ee_req && ee_ack) begin
            ee_req  <= 1'b0;
            rd_byte <= ee_rdata;
        end else if (go && !ee_req) begin
            ee_req   <= 1'b1;
            ee_we    <= go_we;
            ee_addr  <= go_addr;
            ee_wdata <= go_wdata;
        end
    end

    // Completion strobe, one cycle after the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= ee_req && ee_ack;
    end

    // R6: request held with stable fields until acknowledged.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));

    // R6: request released the cycle after the acknowledge.
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && ee_ack |=> !ee_req);

endmodule

// File: rtl/nvm_hregs.sv
// Host register file: control request bits, EEPROM address, data byte,
// burst start bit and memory base field. Writes are dropped while busy.
// Request bits are cleared by the sequencer's completion strobes.
// Assumes HW > EE_AW.
module nvm_hregs
    import nvm_pkg::*;
#(
    parameter int HW     = 32,
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [2:0]        h_addr,
    input  logic [HW-1:0]     h_wdata,
    output logic [HW-1:0]     h_rdata,
    input  logic              single_done,
    input  logic              burst_done,
    input  logic [7:0]        rd_byte,
    output logic              wr_bit,
    output logic              rd_bit,
    output logic              burst_bit,
    output logic              busy,
    output logic [EE_AW-1:0]  addr_reg,
    output logic [7:0]        data_reg,
    output logic [BASE_W-1:0] base_reg
);

    logic unused_wbits;
    assign unused_wbits = ^h_wdata[HW-1:EE_AW];

    assign busy = wr_bit | rd_bit | burst_bit;

    // Host writes when idle, plus the self-clearing of request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bit    <= 1'b0;
            rd_bit    <= 1'b0;
            burst_bit <= 1'b0;
            addr_reg  <= '0;
            data_reg  <= '0;
            base_reg  <= '0;
        end else begin
            if (single_done) begin
                if (rd_bit) data_reg <= rd_byte;
                wr_bit <= 1'b0;
                rd_bit <= 1'b0;
            end
            if (burst_done) burst_bit <= 1'b0;
            if (h_we && !busy) begin
                case (h_addr)
                    OFS_CTRL: begin
                        if (h_wdata[CTL_WR])      wr_bit <= 1'b1;
                        else if (h_wdata[CTL_RD]) rd_bit <= 1'b1;
                    end
                    OFS_ADDR:  addr_reg  <= h_wdata[EE_AW-1:0];
                    OFS_DATA:  data_reg  <= h_wdata[7:0];
                    OFS_BURST: burst_bit <= h_wdata[0];
                    OFS_BASE:  base_reg  <= h_wdata[BASE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer for the host port.
    always_comb begin
        h_rdata = '0;
        case (h_addr)
            OFS_CTRL:  begin
                h_rdata[CTL_WR]   = wr_bit;
                h_rdata[CTL_RD]   = rd_bit;
                h_rdata[CTL_BUSY] = busy;
            end
            OFS_ADDR:  h_rdata[EE_AW-1:0]  = addr_reg;
            OFS_DATA:  h_rdata[7:0]        = data_reg;
            OFS_BURST: h_rdata[0]          = burst_bit;
            OFS_BASE:  h_rdata[BASE_W-1:0] = base_reg;
            default: ;
        endcase
    end

    // R4: writes while busy leave address and base untouched.
    a_r4_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        h_we && busy |=> $stable(addr_reg) && $stable(base_reg));

    // R5: never more than one request pending.
    a_r5_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_bit, rd_bit, burst_bit}));

    // R2: single request bits are clear after completion.
    a_r2_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        single_done |=> !wr_bit && !rd_bit);

endmodule

// File: rtl/nvm_seq.sv
// Operation sequencer. It runs one single access, or a load of records
// (high byte, low byte, data byte) that ends on an all-ones record address.
// It keeps the byte cursor that each load resumes from and drives the memory
// write port. Assumes EE_AW is 16, so a record address is two bytes.
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9,
    localparam int MEM_AW = BASE_W + EE_AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_bit,
    input  logic              rd_bit,
    input  logic              burst_bit,
    input  logic [EE_AW-1:0]  addr_reg,
    input  logic [7:0]        data_reg,
    input  logic [BASE_W-1:0] base_reg,
    input  logic              done,
    input  logic [7:0]        rd_byte,
    output logic              go,
    output logic              go_we,
    output logic [EE_AW-1:0]  go_addr,
    output logic [7:0]        go_wdata,
    output logic              single_done,
    output logic              burst_done,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    seq_state_t       state;
    logic [EE_AW-1:0] cursor;
    logic [EE_AW-9:0] hi_q;
    logic [7:0]       lo_q;
    logic             single_req;
    logic             term;

    assign single_req = wr_bit | rd_bit;
    assign term       = ({hi_q, rd_byte} == {EE_AW{1'b1}});

    // Request issue and completion strobes for the current state.
    always_comb begin
        go          = 1'b0;
        go_we       = 1'b0;
        go_addr     = cursor;
        go_wdata    = data_reg;
        single_done = 1'b0;
        burst_done  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (single_req) begin
                    go      = 1'b1;
                    go_we   = wr_bit;
                    go_addr = addr_reg;
                end else if (burst_bit) begin
                    go = 1'b1;
                end
            end
            ST_SINGLE: single_done = done;
            ST_HI:     go = done;
            ST_LO: begin
                go         = done && !term;
                burst_done = done && term;
            end
            ST_DAT:    go = done;
            default: ;
        endcase
    end

    // State, cursor, record capture and memory write register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cursor    <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (go && !(state == ST_IDLE && single_req)) cursor <= cursor + 1'b1;
            case (state)
                ST_IDLE: begin
                    if (single_req)     state <= ST_SINGLE;
                    else if (burst_bit) state <= ST_HI;
                end
                ST_SINGLE: if (done) begin
                    cursor <= addr_reg + 1'b1;
                    state  <= ST_IDLE;
                end
                ST_HI: if (done) begin
                    hi_q  <= rd_byte[EE_AW-9:0];
                    state <= ST_LO;
                end
                ST_LO: if (done) begin
                    lo_q  <= rd_byte;
                    state <= term ? ST_IDLE : ST_DAT;
                end
                ST_DAT: if (done) begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {base_reg, hi_q[EE_AW-10:0], lo_q};
                    mem_wdata <= rd_byte;
                    state     <= ST_HI;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: each memory write is a single-cycle pulse.
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R9: the upper address bits come from the base field.
    a_r9_base: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[MEM_AW-1:EE_AW-1] == base_reg);

endmodule

// File: rtl/nvm_loader.sv
// Top of the EEPROM access sequencer. It joins the host register file, the
// operation sequencer and the EEPROM handshake driver.
// Assumes a single clock domain and a synchronous active-low reset.
module nvm_loader #(
    parameter int HW     = 32,
    parameter int EE_AW  = 16,
    parameter int MEM_AW = 24,
    localparam int BASE_W = MEM_AW - EE_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [2:0]        h_addr,
    input  logic [HW-1:0]     h_wdata,
    output logic [HW-1:0]     h_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    input  logic              ee_ack,
    input  logic [7:0]        ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    logic              wr_bit, rd_bit, burst_bit, busy;
    logic [EE_AW-1:0]  addr_reg;
    logic [7:0]        data_reg;
    logic [BASE_W-1:0] base_reg;
    logic              single_done, burst_done, done;
    logic [7:0]        rd_byte;
    logic              go, go_we;
    logic [EE_AW-1:0]  go_addr;
    logic [7:0]        go_wdata;
    logic              unused_busy;

    assign unused_busy = busy;

    nvm_hregs #(.HW(HW), .EE_AW(EE_AW), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .single_done(single_done), .burst_done(burst_done), .rd_byte(rd_byte),
        .wr_bit(wr_bit), .rd_bit(rd_bit), .burst_bit(burst_bit), .busy(busy),
        .addr_reg(addr_reg), .data_reg(data_reg), .base_reg(base_reg)
    );

    nvm_seq #(.EE_AW(EE_AW), .BASE_W(BASE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_bit(wr_bit), .rd_bit(rd_bit), .burst_bit(burst_bit),
        .addr_reg(addr_reg), .data_reg(data_reg), .base_reg(base_reg),
        .done(done), .rd_byte(rd_byte),
        .go(go), .go_we(go_we), .go_addr(go_addr), .go_wdata(go_wdata),
        .single_done(single_done), .burst_done(burst_done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    nvm_ee_if #(.EE_AW(EE_AW)) u_ee (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_we(go_we), .go_addr(go_addr), .go_wdata(go_wdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata), .done(done), .rd_byte(rd_byte)
    );

endmodule

// File: tb/sim_nvm_loader.sv
module sim_nvm_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_we = 1'b0;
    logic [2:0]  h_addr = 3'd0;
    logic [31:0] h_wdata = 32'd0;
    logic [31:0] h_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = 8'd0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0]  rom [0:255];
    int          dly = 0;
    logic [15:0] acc_addr [0:63];
    logic        acc_we [0:63];
    int          acc_n = 0;
    logic [23:0] mw_addr [0:15];
    logic [7:0]  mw_data [0:15];
    int          mw_n = 0;

    always #10 clk = ~clk;

    nvm_loader u0 (
        .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
        .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // EEPROM model: acknowledges each request after three cycles, one-cycle ack.
    always @(posedge clk) begin
        ee_ack <= 1'b0;
        if (ee_req && !ee_ack) begin
            if (dly == 2) begin
                dly    <= 0;
                ee_ack <= 1'b1;
                if (ee_we) rom[ee_addr[7:0]] <= ee_wdata;
                else       ee_rdata <= rom[ee_addr[7:0]];
                if (acc_n < 64) begin
                    acc_addr[acc_n] <= ee_addr;
                    acc_we[acc_n]   <= ee_we;
                end
                acc_n <= acc_n + 1;
            end else begin
                dly <= dly + 1;
            end
        end
    end

    // Memory write log.
    always @(posedge clk) begin
        if (mem_we) begin
            if (mw_n < 16) begin
                mw_addr[mw_n] <= mem_addr;
                mw_data[mw_n] <= mem_wdata;
            end
            mw_n <= mw_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        h_addr = a;
        #1 d = h_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            hrd(3'd0, v);
            if (!v[2]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            hrd(3'(a), v);
            chk(v == 0, "R1 reg reset", v, 0);
        end
        chk(!ee_req && !mem_we, "R1 outputs idle", {ee_req, mem_we}, 0);
    endtask

    task automatic t_first_burst();
        logic [31:0] v;
        int a0;
        rom[0] = 8'h92; rom[1] = 8'h34; rom[2] = 8'hA7;
        rom[3] = 8'h00; rom[4] = 8'h10; rom[5] = 8'h5C;
        rom[6] = 8'hFF; rom[7] = 8'hFF; rom[8] = 8'h77;
        hwr(3'd4, 32'h1A5);
        a0 = acc_n;
        hwr(3'd3, 32'h1);
        hrd(3'd0, v);
        chk(v[2] == 1'b1, "R4 busy during burst", v, 32'h4);
        wait_idle();
        hrd(3'd3, v);
        chk(v == 0, "R7 burst bit self-clears", v, 0);
        chk(acc_addr[a0] == 16'h0000, "R7 first burst at 0", acc_addr[a0], 0);
        chk(acc_n - a0 == 8, "R10 no data read for terminator", acc_n - a0, 8);
        chk(mw_n == 2, "R10 no memory write for terminator", mw_n, 2);
        chk(mw_addr[0] == {9'h1A5, 15'h1234}, "R9 addr drops bit 15", mw_addr[0], {9'h1A5, 15'h1234});
        chk(mw_data[0] == 8'hA7, "R9 data 0", mw_data[0], 8'hA7);
        chk(mw_addr[1] == {9'h1A5, 15'h0010}, "R9 addr 1", mw_addr[1], {9'h1A5, 15'h0010});
        chk(mw_data[1] == 8'h5C, "R9 data 1", mw_data[1], 8'h5C);
    endtask

    task automatic t_single_write();
        logic [31:0] v;
        int a0;
        hwr(3'd1, 32'h40);
        hwr(3'd2, 32'h3C);
        a0 = acc_n;
        hwr(3'd0, 32'h1);
        wait_idle();
        hrd(3'd0, v);
        chk(v == 0, "R2 write bit self-clears", v, 0);
        chk(rom[8'h40] == 8'h3C, "R2 byte written", rom[8'h40], 8'h3C);
        chk(acc_we[a0] == 1'b1 && acc_addr[a0] == 16'h40, "R2 write access", acc_addr[a0], 16'h40);
    endtask

    task automatic t_single_read();
        logic [31:0] v;
        rom[8'h41] = 8'h99;
        hwr(3'd1, 32'h41);
        hwr(3'd0, 32'h2);
        wait_idle();
        hrd(3'd0, v);
        chk(v == 0, "R3 read bit self-clears", v, 0);
        hrd(3'd2, v);
        chk(v == 32'h99, "R3 data loaded", v, 32'h99);
    endtask

    task automatic t_resume_burst();
        int a0;
        rom[8'h42] = 8'hFF; rom[8'h43] = 8'hFF;
        rom[8'h44] = 8'h85; rom[8'h45] = 8'h01; rom[8'h46] = 8'h6E;
        rom[8'h47] = 8'hFF; rom[8'h48] = 8'hFF;
        a0 = acc_n;
        hwr(3'd3, 32'h1);
        wait_idle();
        chk(acc_addr[a0] == 16'h42, "R8 resume after single", acc_addr[a0], 16'h42);
        chk(mw_n == 2, "R10 empty burst writes nothing", mw_n, 2);
        a0 = acc_n;
        hwr(3'd3, 32'h1);
        wait_idle();
        chk(acc_addr[a0] == 16'h44, "R8 resume after burst", acc_addr[a0], 16'h44);
        chk(mw_n == 3 && mw_addr[2] == {9'h1A5, 15'h0501}, "R9 bit 15 dropped", mw_addr[2], {9'h1A5, 15'h0501});
        chk(mw_data[2] == 8'h6E, "R9 data 2", mw_data[2], 8'h6E);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int a0;
        rom[8'h20] = 8'h5A;
        hwr(3'd1, 32'h20);
        a0 = acc_n;
        hwr(3'd0, 32'h2);
        hwr(3'd1, 32'h77);
        hwr(3'd4, 32'h0F0);
        hwr(3'd0, 32'h1);
        wait_idle();
        hrd(3'd1, v);
        chk(v == 32'h20, "R4 addr write ignored", v, 32'h20);
        hrd(3'd4, v);
        chk(v == 32'h1A5, "R4 base write ignored", v, 32'h1A5);
        repeat (10) @(negedge clk);
        chk(acc_n - a0 == 1, "R4 request ignored", acc_n - a0, 1);
        hrd(3'd2, v);
        chk(v == 32'h5A, "R3 read while busy", v, 32'h5A);
    endtask

    task automatic t_both_bits();
        logic [31:0] v;
        int a0;
        rom[8'h50] = 8'h00;
        hwr(3'd1, 32'h50);
        hwr(3'd2, 32'h21);
        a0 = acc_n;
        hwr(3'd0, 32'h3);
        wait_idle();
        chk(acc_n - a0 == 1 && acc_we[a0] == 1'b1, "R5 only write done", acc_we[a0], 1);
        chk(rom[8'h50] == 8'h21, "R5 byte written", rom[8'h50], 8'h21);
        hrd(3'd2, v);
        chk(v == 32'h21, "R5 data kept", v, 32'h21);
    endtask

    task automatic t_data_width();
        logic [31:0] v;
        hwr(3'd2, 32'hFFFF_ABCD);
        hrd(3'd2, v);
        chk(v == 32'hCD, "R11 data register 8 bits", v, 32'hCD);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_burst();
        t_single_write();
        t_single_read();
        t_resume_burst();
        t_busy_ignore();
        t_both_bits();
        t_data_width();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule